// File: doc/BRIEF.md
# Dual-Slope Phase-Correct PWM Timer

This block is a 16-bit triangular counter that drives two symmetric pulse-width-modulated outputs. On each cycle where the prescaled `tick` enable is high, the counter takes one step. It climbs from zero to a ceiling value, shows that ceiling for exactly one tick, then descends back to zero. It shows zero for one tick and climbs again. Each channel compares the count against its own compare value. The output is driven low on a match during the climb and high on a match during the descent. This centres each pulse on the counter's bottom, which motor-drive bridges need.

The ceiling comes from a mode code. Three codes give fixed 8-, 9- and 10-bit ceilings. Two codes take the ceiling from a register: either a dedicated ceiling input or channel A's compare value. The ceiling and both compare values are double-buffered. Their inputs are sampled into active copies only when the counter turns around at the ceiling, and once on the first tick after reset. A period can therefore never be cut short or glitched by a mid-cycle update.

The counter is a two-state machine. In state `SLOPE_UP` it increments. The transition "turn" moves it to `SLOPE_DOWN`: this is taken on a tick where the count is at or above the ceiling, and the count then decrements. In state `SLOPE_DOWN` it decrements. The transition "rebound" moves it to `SLOPE_UP`: this is taken on a tick where the count is zero, and the count becomes 1. Reset places the machine in `SLOPE_DOWN` with count zero.

Top module: `dualslope_pwm`

## Requirements
- R1: After reset, `count` is 0, `dir_down` is 1, `bottom_pulse` is 0, and each `pwm[i]` equals `inv[i]`.
- R2: `count`, `dir_down` and `pwm` change only on the clock edge that ends a cycle in which `tick` is 1.
- R3: With `tick` high, `count` runs 0,1,…,TOP,TOP-1,…,1,0,1,… so that TOP and 0 each last one tick and one full cycle lasts 2×TOP ticks. `dir_down` is 0 from the count 1 up to TOP, and is 1 from TOP-1 down to 0.
- R4: The ceiling depends on `mode`. Code 1 gives 0x00FF, code 2 gives 0x01FF and code 3 gives 0x03FF. Code 10 uses the active copy of `top_reg`, and code 11 uses the active copy of `cmp_a`. Every other code gives 0x00FF.
- R5: In codes 10 and 11, a register-defined ceiling below 3 is raised to 3. Values up to 0xFFFF are used as given.
- R6: `top_reg`, `cmp_a` and `cmp_b` are copied to their active versions on the turn tick and on the first tick after reset. At all other times, changes to these inputs have no effect. Before the first copy, the active values are 0xFFFF.
- R7: For a channel with `inv[i]`=0, `pwm[i]` goes to 0 after a tick on which `dir_down`=0 and `count` equals the channel's active compare value. It goes to 1 after such a tick with `dir_down`=1. Channel 0 uses `cmp_a` and channel 1 uses `cmp_b`.
- R8: With `inv[i]`=1, `pwm[i]` is the complement of the non-inverted waveform of R7.
- R9: A non-inverted channel with compare value 0 stays at 1 once the first descent has reached 0. A compare value equal to TOP keeps it at 0.
- R10: `bottom_pulse` is 1 for exactly one clock in the cycle where `count` has just become 0 on the descent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled count enable |
| mode | input | 4 | Ceiling selection code |
| top_reg | input | 16 | Buffered ceiling value for code 10 |
| cmp_a | input | 16 | Buffered compare value, channel 0 (ceiling for code 11) |
| cmp_b | input | 16 | Buffered compare value, channel 1 |
| inv | input | 2 | Per-channel output inversion |
| pwm | output | 2 | PWM outputs |
| count | output | 16 | Current counter value |
| dir_down | output | 1 | 1 while the counter is descending |
| bottom_pulse | output | 1 | One-clock pulse when the counter reaches 0 |

## Verification
Two pairs of events can fall on the same tick. In the first pair, the buffer copy on the turn tick coincides with a compare match at the ceiling. In the second pair, the rebound at zero coincides with a down-slope match of a zero compare value. The bench forces both by sweeping every compare value from 0 to TOP+1 against small register-defined ceilings, and by using code 11, where channel A's compare value is also the ceiling. It also changes `cmp_a` and `top_reg` in the middle of a climb. The judgement is that each match acts on the compare value that was active before the copy: the peak of the running period stays at the old ceiling, and the new values take hold only in the next period.

// File: rtl/dspwm_pkg.sv
package dspwm_pkg;
    localparam int MODE_W = 4;
    typedef logic [MODE_W-1:0] mode_t;

    localparam mode_t MODE_RES8    = 4'd1;
    localparam mode_t MODE_RES9    = 4'd2;
    localparam mode_t MODE_RES10   = 4'd3;
    localparam mode_t MODE_TOPREG  = 4'd10;
    localparam mode_t MODE_TOPCMPA = 4'd11;

    typedef enum logic [0:0] {
        SLOPE_UP   = 1'b0,
        SLOPE_DOWN = 1'b1
    } slope_e;
endpackage

// File: rtl/dspwm_top_sel.sv
module dspwm_top_sel
    import dspwm_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int MIN_TOP = 3
) (
    input  mode_t            mode,
    input  logic [CNT_W-1:0] act_top,
    input  logic [CNT_W-1:0] act_cmp_a,
    output logic [CNT_W-1:0] top
);
    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_TOP);
    localparam logic [CNT_W-1:0] TOP8  = CNT_W'((1 << 8) - 1);
    localparam logic [CNT_W-1:0] TOP9  = CNT_W'((1 << 9) - 1);
    localparam logic [CNT_W-1:0] TOP10 = CNT_W'((1 << 10) - 1);

    always_comb begin
        unique case (mode)
            MODE_RES9:    top = TOP9;
            MODE_RES10:   top = TOP10;
            MODE_TOPREG:  top = (act_top < FLOOR) ? FLOOR : act_top;
            MODE_TOPCMPA: top = (act_cmp_a < FLOOR) ? FLOOR : act_cmp_a;
            default:      top = TOP8;
        endcase
    end
endmodule

// File: rtl/dspwm_counter.sv
module dspwm_counter
    import dspwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] top,
    output logic [CNT_W-1:0] count,
    output slope_e           slope,
    output logic             at_turn,
    output logic             bottom_pulse
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    slope_e           state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             pulse_q;

    // next-state and next-count decision
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        at_turn = 1'b0;
        if (tick) begin
            unique case (state_q)
                SLOPE_UP: begin
                    if (cnt_q >= top) begin
                        state_d = SLOPE_DOWN;
                        cnt_d   = cnt_q - ONE;
                        at_turn = 1'b1;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
                SLOPE_DOWN: begin
                    if (cnt_q == '0) begin
                        state_d = SLOPE_UP;
                        cnt_d   = ONE;
                    end else begin
                        cnt_d = cnt_q - ONE;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLOPE_DOWN;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= tick && (state_q == SLOPE_DOWN) && (cnt_q == ONE);
        end
    end

    assign count        = cnt_q;
    assign slope        = state_q;
    assign bottom_pulse = pulse_q;
endmodule

// File: rtl/dspwm_channel.sv
module dspwm_channel
    import dspwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  slope_e           slope,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp,
    input  logic             inv,
    output logic             pwm
);
    logic wave_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wave_q <= 1'b0;
        end else if (tick && (count == cmp)) begin
            wave_q <= (slope == SLOPE_DOWN);
        end
    end

    assign pwm = wave_q ^ inv;
endmodule

// File: rtl/dualslope_pwm.sv
module dualslope_pwm
    import dspwm_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int MIN_TOP = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [3:0]       mode,
    input  logic [CNT_W-1:0] top_reg,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic [1:0]       inv,
    output logic [1:0]       pwm,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             bottom_pulse
);
    localparam int NUM_CH = 2;

    logic [CNT_W-1:0] cmp_in  [NUM_CH];
    logic [CNT_W-1:0] act_cmp [NUM_CH];
    logic [CNT_W-1:0] act_top;
    logic [CNT_W-1:0] top_now;
    logic             load_pend;
    logic             at_turn;
    logic             load_now;
    slope_e           slope;

    assign cmp_in[0] = cmp_a;
    assign cmp_in[1] = cmp_b;
    assign load_now  = tick && (at_turn || load_pend);

    // double buffer: copy at the turn tick or the first tick after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_pend <= 1'b1;
            act_top   <= '1;
            for (int c = 0; c < NUM_CH; c++) act_cmp[c] <= '1;
        end else if (load_now) begin
            load_pend <= 1'b0;
            act_top   <= top_reg;
            for (int c = 0; c < NUM_CH; c++) act_cmp[c] <= cmp_in[c];
        end
    end

    dspwm_top_sel #(.CNT_W(CNT_W), .MIN_TOP(MIN_TOP)) i_top_sel (
        .mode      (mode),
        .act_top   (act_top),
        .act_cmp_a (act_cmp[0]),
        .top       (top_now)
    );

    dspwm_counter #(.CNT_W(CNT_W)) i_counter (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .top          (top_now),
        .count        (count),
        .slope        (slope),
        .at_turn      (at_turn),
        .bottom_pulse (bottom_pulse)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dspwm_channel #(.CNT_W(CNT_W)) i_channel (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .slope (slope),
            .count (count),
            .cmp   (act_cmp[g]),
            .inv   (inv[g]),
            .pwm   (pwm[g])
        );
    end

    assign dir_down = (slope == SLOPE_DOWN);
endmodule

// File: rtl/dspwm_checker.sv
module dspwm_checker #(
    parameter int CNT_W   = 16,
    parameter int MIN_TOP = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] top,
    input logic             dir_down,
    input logic             bottom_pulse,
    input logic [1:0]       pwm,
    input logic [1:0]       inv
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(count) && $stable(dir_down)));

    assert_wave_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && $stable(inv)) |=> $stable(pwm));

    assert_climb_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !dir_down && (count < top)) |=> (!dir_down && (count == $past(count) + ONE)));

    assert_turn_at_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !dir_down && (count >= top)) |=> (dir_down && (count == $past(count) - ONE)));

    assert_top_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        top >= CNT_W'(MIN_TOP));

    assert_pulse_at_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bottom_pulse |-> (count == '0 && dir_down));

    assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bottom_pulse |=> !bottom_pulse);
endmodule

bind dualslope_pwm dspwm_checker #(.CNT_W(CNT_W), .MIN_TOP(MIN_TOP)) i_dspwm_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick         (tick),
    .count        (count),
    .top          (top_now),
    .dir_down     (dir_down),
    .bottom_pulse (bottom_pulse),
    .pwm          (pwm),
    .inv          (inv)
);

// File: tb/test_dualslope_pwm.sv
module test_dualslope_pwm;
    localparam int CLK_PERIOD = 10;
    localparam int CW         = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic [3:0]    mode = 4'd1;
    logic [CW-1:0] top_reg = '0;
    logic [CW-1:0] cmp_a = '0;
    logic [CW-1:0] cmp_b = '0;
    logic [1:0]    inv = 2'b00;
    logic [1:0]    pwm;
    logic [CW-1:0] count;
    logic          dir_down;
    logic          bottom_pulse;

    int checks = 0;
    int errors = 0;

    // expected-behaviour state
    int m_cnt, m_down, m_pulse, m_atop, m_pend;
    int m_raw [2];
    int m_acmp [2];

    always #(CLK_PERIOD / 2) clk = ~clk;

    dualslope_pwm i_dualslope_pwm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .top_reg(top_reg),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .inv(inv), .pwm(pwm), .count(count),
        .dir_down(dir_down), .bottom_pulse(bottom_pulse)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_top(input int md, input int atop, input int acmpa);
        case (md)
            2:  return 511;
            3:  return 1023;
            10: return (atop < 3) ? 3 : atop;
            11: return (acmpa < 3) ? 3 : acmpa;
            default: return 255;
        endcase
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_down = 1; m_pulse = 0; m_atop = 65535; m_pend = 1;
        for (int c = 0; c < 2; c++) begin m_raw[c] = 0; m_acmp[c] = 65535; end
    endtask

    task automatic model_tick();
        int t;
        int ld;
        m_pulse = 0;
        if (tick) begin
            t  = exp_top(int'(mode), m_atop, m_acmp[0]);
            for (int c = 0; c < 2; c++) if (m_cnt == m_acmp[c]) m_raw[c] = m_down;
            ld = m_pend;
            if (m_down == 0) begin
                if (m_cnt >= t) begin m_cnt = m_cnt - 1; m_down = 1; ld = 1; end
                else m_cnt = m_cnt + 1;
            end else begin
                if (m_cnt == 0) begin m_cnt = 1; m_down = 0; end
                else begin if (m_cnt == 1) m_pulse = 1; m_cnt = m_cnt - 1; end
            end
            if (ld != 0) begin
                m_atop = int'(top_reg); m_acmp[0] = int'(cmp_a); m_acmp[1] = int'(cmp_b); m_pend = 0;
            end
        end
    endtask

    task automatic check_outputs();
        check("R3 count", int'(count), m_cnt);
        check("R3 dir_down", int'(dir_down), m_down);
        check("R7/R8 pwm0", int'(pwm[0]), m_raw[0] ^ int'(inv[0]));
        check("R7/R8 pwm1", int'(pwm[1]), m_raw[1] ^ int'(inv[1]));
        check("R10 bottom_pulse", int'(bottom_pulse), m_pulse);
    endtask

    // caller sets inputs at a negedge, then calls step
    task automatic step();
        model_tick();
        @(posedge clk);
        @(negedge clk);
        check_outputs();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic measure(output int period, output int peak);
        int seen = 0;
        int first = 0;
        int cyc = 0;
        period = 0; peak = 0;
        while (seen < 2 && cyc < 6000) begin
            step();
            cyc++;
            if (seen == 1 && int'(count) > peak) peak = int'(count);
            if (bottom_pulse) begin
                seen++;
                if (seen == 1) first = cyc; else period = cyc - first;
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int per, pk, t, c0;
        int md_list [7] = '{1, 2, 3, 10, 11, 0, 7};

        // R1: reset state
        inv = 2'b10;
        do_reset();
        check("R1 count", int'(count), 0);
        check("R1 dir_down", int'(dir_down), 1);
        check("R1 bottom_pulse", int'(bottom_pulse), 0);
        check("R1 pwm", int'(pwm), 2);

        // R4: ceiling per mode code, R3 period 2*TOP
        foreach (md_list[i]) begin
            mode = md_list[i][3:0]; top_reg = 16'd37; cmp_a = 16'd20; cmp_b = 16'd5; inv = 2'b00; tick = 1'b1;
            do_reset();
            measure(per, pk);
            t = exp_top(md_list[i], 37, 20);
            check($sformatf("R4 peak mode %0d", md_list[i]), pk, t);
            check($sformatf("R3 period mode %0d", md_list[i]), per, 2 * t);
        end

        // R5: register ceilings below 3 clamp to 3
        mode = 4'd10; top_reg = 16'd1; do_reset();
        measure(per, pk);
        check("R5 clamped peak", pk, 3);
        check("R5 clamped period", per, 6);

        // R2: sparse ticks
        mode = 4'd10; top_reg = 16'd5; cmp_a = 16'd2; cmp_b = 16'd4; do_reset();
        for (int k = 0; k < 60; k++) begin
            tick = (k % 3 == 0);
            c0 = int'(count);
            step();
            if (!tick) check("R2 count held without tick", int'(count), c0);
        end
        tick = 1'b1;

        // R6: mid-climb update waits for the turn
        mode = 4'd10; top_reg = 16'd10; cmp_a = 16'd3; cmp_b = 16'd3; inv = 2'b00; do_reset();
        measure(per, pk);
        while (int'(count) != 5 || dir_down) step();
        top_reg = 16'd4; cmp_a = 16'd9; cmp_b = 16'd1;
        pk = 0;
        while (!dir_down) begin step(); if (int'(count) > pk) pk = int'(count); end
        check("R6 peak keeps old TOP", pk, 10);
        measure(per, pk);
        check("R6 new TOP in next period", pk, 4);

        // R7/R8/R9 sweep: register ceilings and code 11
        for (int md = 10; md <= 11; md++) begin
            for (int tr = 0; tr <= 6; tr++) begin
                for (int a = 0; a <= 7; a++) begin
                    for (int b = 0; b <= 7; b++) begin
                        if (md == 11 && tr > 0) continue;
                        mode = md[3:0]; top_reg = 16'(tr); cmp_a = 16'(a); cmp_b = 16'(b);
                        inv = {a[0] ^ b[0], a[1]};
                        do_reset();
                        t = exp_top(md, tr, a);
                        for (int k = 0; k < 8 * t + 4; k++) step();
                    end
                end
            end
        end

        // R9: compare 0 stays high, compare at TOP stays low (non-inverted)
        mode = 4'd10; top_reg = 16'd6; cmp_a = 16'd0; cmp_b = 16'd6; inv = 2'b00; do_reset();
        measure(per, pk);
        for (int k = 0; k < 14; k++) begin
            step();
            check("R9 compare 0 held high", int'(pwm[0]), 1);
            check("R9 compare TOP held low", int'(pwm[1]), 0);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule